// File: doc/BRIEF.md
# Next-PC and link-operand unit

This block sits in the decode stage of a simple 32-bit load/store RISC core. It owns the program counter register. Each cycle it decides which address is fetched next, and it supplies the first operand passed on to the execute stage.

The next address comes from one of three sources:
- the sequential successor, the current PC plus 4;
- a relative target, the current PC plus a sign-extended offset supplied by the decoder;
- an absolute target, read directly from a register value.

A zero test on one register read value decides conditional branches. A first multiplexer chooses between the sequential and relative paths. A second multiplexer, controlled by the instruction class, can override both with the register value.

For link jumps, the operand-A output carries the sequential successor instead of the register read value, so that the return address can be written back later. The instruction class and the register values are plain decode-stage signals with no handshake. A `hold` input freezes the PC, which is the only form of back-pressure the block accepts.

Top module: `pc_steer`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_q` becomes 0 on that edge, whatever `hold` and `cls` are.
- R2: When `hold` is high and `rst` is low at a rising edge, `pc_q` keeps its value.
- R3: Class code 0 (sequential) and the reserved code 7 load `pc_q + 4`.
- R4: Class code 1 (branch if zero) loads `pc_q + br_off` when `tst_val` is zero, and `pc_q + 4` otherwise.
- R5: Class code 2 (branch if nonzero) loads `pc_q + br_off` when `tst_val` is nonzero, and `pc_q + 4` otherwise.
- R6: Class codes 3 (jump) and 4 (jump and link) always load `pc_q + br_off`, whatever the value of `tst_val`.
- R7: Class codes 5 (register jump) and 6 (register jump and link) load `tst_val` unchanged.
- R8: In the same cycle, `opa` equals `pc_q + 4` for class codes 4 and 6, and equals `src_val` for every other code, whether `hold` is high or low.
- R9: All PC arithmetic wraps modulo 2^32, and `br_off` is treated as a signed two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Stall: keeps the PC unchanged |
| cls | input | 3 | Decoded instruction class code |
| br_off | input | 32 | Sign-extended branch or jump offset |
| tst_val | input | 32 | Register value used for the zero test and as the register jump target |
| src_val | input | 32 | Register value that is the normal operand A |
| pc_q | output | 32 | Current program counter |
| opa | output | 32 | Operand A sent to the execute stage |

## Verification
A register jump with link exercises two functions in one cycle. The link substitution drives `opa` to `pc_q + 4`, while the second-level multiplexer loads the PC from `tst_val`. The bench provokes this with distinct, nonzero values on `tst_val` and `src_val`. It checks `opa` before the edge and `pc_q` after it, against a behavioural model.

A link jump taken with `hold` high is also covered. In that case the operand must still show the return address while the PC stays frozen. Randomized cycles mix both cases with branches whose test value is zero or nonzero, and with negative offsets. The PC is also placed at the top of the address space to exercise wraparound.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ   = 3'd0,
    CLS_BEQZ  = 3'd1,
    CLS_BNEZ  = 3'd2,
    CLS_JMP   = 3'd3,
    CLS_JMPL  = 3'd4,
    CLS_JREG  = 3'd5,
    CLS_JREGL = 3'd6,
    CLS_RSVD  = 3'd7
  } insn_cls_e;

  function automatic logic is_link(insn_cls_e c);
    return (c == CLS_JMPL) || (c == CLS_JREGL);
  endfunction
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval
  import pc_steer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  insn_cls_e        cls,
  input  logic [XLEN-1:0]  tst_val,
  output logic             take_rel,
  output logic             take_reg
);
  logic is_zero;

  assign is_zero = (tst_val == '0);

  always_comb begin
    take_rel = 1'b0;
    take_reg = 1'b0;
    unique case (cls)
      CLS_BEQZ:             take_rel = is_zero;
      CLS_BNEZ:             take_rel = !is_zero;
      CLS_JMP, CLS_JMPL:    take_rel = 1'b1;
      CLS_JREG, CLS_JREGL:  take_reg = 1'b1;
      default: begin
        take_rel = 1'b0;
        take_reg = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pc_target_sel.sv
module pc_target_sel #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] br_off,
  input  logic [XLEN-1:0] tst_val,
  input  logic            take_rel,
  input  logic            take_reg,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] nxt_pc
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] lvl1;

  assign seq_pc = pc + STEP_V;
  assign rel_pc = pc + br_off;

  // first level: sequential or relative, steered by the zero test
  assign lvl1   = take_rel ? rel_pc : seq_pc;
  // second level: register target overrides both
  assign nxt_pc = take_reg ? tst_val : lvl1;
endmodule

// File: rtl/link_operand_sel.sv
module link_operand_sel
  import pc_steer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  insn_cls_e       cls,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] opa
);
  assign opa = is_link(cls) ? seq_pc : src_val;
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [2:0]      cls,
  input  logic [XLEN-1:0] br_off,
  input  logic [XLEN-1:0] tst_val,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] opa
);
  insn_cls_e       cls_e;
  logic            take_rel;
  logic            take_reg;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] nxt_pc;

  assign cls_e = insn_cls_e'(cls);

  pc_cond_eval #(.XLEN(XLEN)) u_cond (
    .cls      (cls_e),
    .tst_val  (tst_val),
    .take_rel (take_rel),
    .take_reg (take_reg)
  );

  pc_target_sel #(.XLEN(XLEN), .STEP(STEP)) u_tgt (
    .pc       (pc_q),
    .br_off   (br_off),
    .tst_val  (tst_val),
    .take_rel (take_rel),
    .take_reg (take_reg),
    .seq_pc   (seq_pc),
    .nxt_pc   (nxt_pc)
  );

  link_operand_sel #(.XLEN(XLEN)) u_link (
    .cls     (cls_e),
    .seq_pc  (seq_pc),
    .src_val (src_val),
    .opa     (opa)
  );

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= RESET_PC;
    else if (!hold) pc_q <= nxt_pc;
  end
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk #(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            hold,
  input logic [2:0]      cls,
  input logic [XLEN-1:0] br_off,
  input logic [XLEN-1:0] tst_val,
  input logic [XLEN-1:0] src_val,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] opa
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc_q == RESET_PC);

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(pc_q));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && (cls == 3'd0 || cls == 3'd7)) |=> pc_q == $past(pc_q) + STEP_V);

  // R4
  beqz_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && cls == 3'd1) |=>
      pc_q == $past(pc_q) + (($past(tst_val) == '0) ? $past(br_off) : STEP_V));

  // R5
  bnez_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && cls == 3'd2) |=>
      pc_q == $past(pc_q) + (($past(tst_val) != '0) ? $past(br_off) : STEP_V));

  // R6
  jump_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && (cls == 3'd3 || cls == 3'd4)) |=> pc_q == $past(pc_q) + $past(br_off));

  // R7
  jump_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && (cls == 3'd5 || cls == 3'd6)) |=> pc_q == $past(tst_val));

  // R8
  link_opa_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == 3'd4 || cls == 3'd6) |-> opa == pc_q + STEP_V);

  // R8
  plain_opa_chk: assert property (@(posedge clk) disable iff (rst)
    !(cls == 3'd4 || cls == 3'd6) |-> opa == src_val);
endmodule

bind pc_steer pc_steer_chk #(.XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .cls(cls), .br_off(br_off),
  .tst_val(tst_val), .src_val(src_val), .pc_q(pc_q), .opa(opa)
);

// File: tb/pc_steer_bench.sv
`timescale 1ns/1ps
module pc_steer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b0;
  logic [2:0]  cls = 3'd0;
  logic [31:0] br_off = '0;
  logic [31:0] tst_val = '0;
  logic [31:0] src_val = '0;
  logic [31:0] pc_q;
  logic [31:0] opa;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_pc = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pc_steer u_pc_steer (
    .clk(clk), .rst(rst), .hold(hold), .cls(cls), .br_off(br_off),
    .tst_val(tst_val), .src_val(src_val), .pc_q(pc_q), .opa(opa)
  );

  function automatic string tag_of(logic r, logic h, logic [2:0] c);
    if (r) return "R1";
    if (h) return "R2";
    case (c)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] p, logic r, logic h,
      logic [2:0] c, logic [31:0] off, logic [31:0] t);
    if (r) return 32'd0;
    if (h) return p;
    case (c)
      3'd1: return (t == 0) ? p + off : p + 32'd4;
      3'd2: return (t != 0) ? p + off : p + 32'd4;
      3'd3, 3'd4: return p + off;
      3'd5, 3'd6: return t;
      default: return p + 32'd4;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check operand A, then PC after the edge
  task automatic step(logic r, logic h, logic [2:0] c, logic [31:0] off,
                      logic [31:0] t, logic [31:0] s);
    logic [31:0] exp_a;
    @(negedge clk);
    rst = r; hold = h; cls = c; br_off = off; tst_val = t; src_val = s;
    #1;
    if (!r) begin
      exp_a = (c == 3'd4 || c == 3'd6) ? m_pc + 32'd4 : s;
      check((c == 3'd4 || c == 3'd6) ? "R8 link" : "R8 plain", opa, exp_a);
    end
    @(posedge clk);
    #1;
    m_pc = ref_next(m_pc, r, h, c, off, t);
    check(tag_of(r, h, c), pc_q, m_pc);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1, 0, 3'd3, 32'h40, 0, 0);
    step(1, 1, 3'd5, 0, 32'h1234, 0);
    // R3 sequential and reserved
    step(0, 0, 3'd0, 32'h100, 0, 32'hAAAA);
    step(0, 0, 3'd7, 32'h100, 0, 32'hBBBB);
    // R4 branch if zero, taken and not taken
    step(0, 0, 3'd1, 32'h20, 0, 32'h1);
    step(0, 0, 3'd1, 32'h20, 32'h5, 32'h2);
    // R5 branch if nonzero, taken (negative offset) and not
    step(0, 0, 3'd2, 32'hFFFF_FFF0, 32'h9, 32'h3);
    step(0, 0, 3'd2, 32'h80, 0, 32'h4);
    // R6 unconditional relative jumps ignore the test value
    step(0, 0, 3'd3, 32'h44, 0, 32'h5);
    step(0, 0, 3'd4, 32'h48, 32'h77, 32'h6);
    // R7 register jumps, R8 link with register redirect same cycle
    step(0, 0, 3'd5, 32'h999, 32'h0000_1000, 32'h7);
    step(0, 0, 3'd6, 32'h999, 32'h0000_2000, 32'hDEAD_BEEF);
    // R2 hold on a link jump: opa still shows return address
    step(0, 1, 3'd4, 32'h400, 0, 32'h8);
    step(0, 1, 3'd6, 32'h400, 32'h5000, 32'h9);
    // R9 wraparound at top of address space
    step(0, 0, 3'd5, 0, 32'hFFFF_FFFC, 0);
    step(0, 0, 3'd0, 0, 0, 0);
    step(0, 0, 3'd5, 0, 32'hFFFF_FFF8, 0);
    step(0, 0, 3'd3, 32'h10, 0, 0);
    // R1 reset mid-run
    step(1, 0, 3'd0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] t;
      t = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      step(($urandom_range(0, 40) == 0), ($urandom_range(0, 5) == 0),
           3'($urandom_range(0, 7)), $urandom, t, $urandom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule